// File: doc/BRIEF.md
# I2C Register Target with Connectivity Self-Test

This block is the serial control port of a lighting controller. It listens on an I2C-compatible bus and answers to the fixed 7-bit device address 0x4C. It holds the controller's small set of control registers and drives their contents straight to the rest of the chip. A write transaction carries the device address, a register pointer and a data byte. A read sets the pointer with a write, then issues a repeated START and the address with the read bit, and the target sends back the selected register. The pad is not modelled: the bus data line arrives as one input and leaves as an enable and a value.

The bus lines are synchronised into the system clock, which must run at least eight times the bus clock. Bits are taken on rising bus-clock edges and driven after falling ones. The register set has five general control bytes at pointers 0x00 to 0x04. It also has a power-mode nibble, a boost-level code and an audio-threshold code, each of which resets to a non-zero value. A self-test register combines one writable start bit with five read-only pass bits, one for each LED channel and one for the flash channel. Setting the start bit raises a request to the analog sensing logic. At the next START on the bus, the per-channel pass inputs are captured, so the outcome can be read in that same transaction.

The controller is a nine-state machine. IDLE waits for a START. ADDR shifts in the address byte. ADDR_ACK, PTR_ACK and DATA_ACK pull the line low for the acknowledge clock. PTR takes in the register pointer. DATA takes in the write byte. TX shifts a register out. TX_ACK samples the master's acknowledge. The transitions are these:
- START in any state goes to ADDR, and STOP in any state goes to IDLE.
- ADDR goes to ADDR_ACK on a match and back to IDLE on a miss.
- ADDR_ACK goes to PTR for a write and to TX for a read.
- PTR goes to PTR_ACK, which goes to DATA.
- DATA goes to DATA_ACK, which goes back to DATA.
- TX goes to TX_ACK. TX_ACK returns to TX after a master ACK and goes to IDLE after a NACK.

Top module: `lumo_i2c_target`

## Requirements
- R1: After a START, the target compares the first byte, taken MSB first, against the address. The upper seven bits must equal 0x4C; bit 0 is the direction, 0 for write and 1 for read. On a match, the target holds the data line low for the whole ninth clock.
- R2: In a write, the second byte sets the register pointer. The third byte is stored into the pointed register, and all eight bits may change at once. The target acknowledges both bytes.
- R3: In a read, the target drives the pointed register MSB first, one bit per clock, after the address+R acknowledge. A master ACK makes it send the same register again. A master NACK ends its driving.
- R4: If the address does not match, the target leaves the ninth clock high (NACK). It then ignores every byte until the next START: it drives nothing and changes no register.
- R5: Reset, active low, restores these values: bytes 0x00–0x04 become 0x00, 0x0B becomes 0x04, 0x0C becomes 0x00, 0x0D becomes 0x07 and 0x2B becomes 0x03.
- R6: Register 0x0B holds the power-mode nibble on its output. Bit 0 is standby-off, bit 1 is boost enable, bit 2 is auto-load enable and bit 3 is frequency select. Bits 7:4 read as 0.
- R7: Register 0x0D keeps bits 3:0 as the boost code, and register 0x2B keeps bits 3:0 as the threshold code. In both, bits 7:4 read as 0.
- R8: A write to an unmapped pointer is acknowledged and discarded. A read of an unmapped pointer returns 0x00.
- R9: In register 0x0C, bit 0 is the test start bit and drives self_test_o. Bits 5:1 are the pass results for LED1, LED2, LED3, LED4 and flash, in that order. Bits 7:6 read as 0.
- R10: While the start bit is set, the next START copies test_ok_i into the pass bits and clears the start bit. Writes never change the pass bits.
- R11: A STOP returns the target to idle from any state. A repeated START behaves exactly like a first START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low reset (external reset or power-on reset) |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | Target drives the data line when high |
| sda_o | output | 1 | Value driven while sda_oe is high |
| test_ok_i | input | NUM_OK (5) | Per-channel pass flags from the LED sensing: LED1..LED4, flash |
| ctl_o | output | NUM_CTL*8 (40) | Control bytes 0x00–0x04; byte n at bits 8n+7:8n |
| mode_o | output | 4 | Power-mode nibble of register 0x0B |
| boost_o | output | 4 | Boost level code of register 0x0D |
| thresh_o | output | 4 | Audio threshold code of register 0x2B |
| self_test_o | output | 1 | Self-test request (start bit of 0x0C) |

## Verification
Writes use alternating, all-ones and sparse byte patterns so that bit-order or shift-count slips show up at a distinguishable output. Reads return those values and the non-zero reset codes through the repeated-START path. A two-byte read tells ACK continuation apart from NACK termination. Two different pass-flag patterns, one captured and one not, separate a capture on START from direct writes to read-only bits. A near-miss address (0x4D) and an unmapped pointer show whether decoding is exact.

// File: rtl/lumo_pkg.sv
package lumo_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK,
        S_DATA, S_DATA_ACK, S_TX, S_TX_ACK
    } lumo_st_t;

    localparam logic [7:0] A_MODE  = 8'h0B;
    localparam logic [7:0] A_TEST  = 8'h0C;
    localparam logic [7:0] A_BOOST = 8'h0D;
    localparam logic [7:0] A_THR   = 8'h2B;

    localparam logic [3:0] MODE_RST  = 4'b0100;
    localparam logic [3:0] BOOST_RST = 4'b0111;
    localparam logic [3:0] THR_RST   = 4'b0011;
endpackage

// File: rtl/lumo_sync.sv
module lumo_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= '1;
            q  <= '1;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/lumo_regs.sv
module lumo_regs import lumo_pkg::*; #(
    parameter int NUM_CTL = 5,
    parameter int NUM_OK  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [7:0]           rd_addr,
    output logic [7:0]           rd_data,
    input  logic                 start_evt,
    input  logic [NUM_OK-1:0]    test_ok_i,
    output logic [NUM_CTL*8-1:0] ctl_o,
    output logic [3:0]           mode_o,
    output logic [3:0]           boost_o,
    output logic [3:0]           thresh_o,
    output logic                 self_test_o
);
    localparam int PAD = 7 - NUM_OK;

    logic [7:0]        ctl_q [NUM_CTL];
    logic [3:0]        mode_q, boost_q, thr_q;
    logic              en_test;
    logic [NUM_OK-1:0] ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CTL; i++) ctl_q[i] <= '0;
            mode_q  <= MODE_RST;
            boost_q <= BOOST_RST;
            thr_q   <= THR_RST;
            en_test <= 1'b0;
            ok_q    <= '0;
        end else begin
            if (en_test && start_evt) begin
                ok_q    <= test_ok_i;
                en_test <= 1'b0;
            end
            if (wr_en) begin
                for (int i = 0; i < NUM_CTL; i++)
                    if (wr_addr == 8'(i)) ctl_q[i] <= wr_data;
                if (wr_addr == A_MODE)  mode_q  <= wr_data[3:0];
                if (wr_addr == A_BOOST) boost_q <= wr_data[3:0];
                if (wr_addr == A_THR)   thr_q   <= wr_data[3:0];
                if (wr_addr == A_TEST)  en_test <= wr_data[0];
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_CTL; i++)
            if (rd_addr == 8'(i)) rd_data = ctl_q[i];
        if (rd_addr == A_MODE)  rd_data = {4'h0, mode_q};
        if (rd_addr == A_BOOST) rd_data = {4'h0, boost_q};
        if (rd_addr == A_THR)   rd_data = {4'h0, thr_q};
        if (rd_addr == A_TEST)  rd_data = {{PAD{1'b0}}, ok_q, en_test};
    end

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        assign ctl_o[8*g +: 8] = ctl_q[g];
    end
    assign mode_o      = mode_q;
    assign boost_o     = boost_q;
    assign thresh_o    = thr_q;
    assign self_test_o = en_test;

    // R10: an armed test captures the pass flags on START and disarms
    p_test_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_test && start_evt) |=> (!en_test && ok_q == $past(test_ok_i)));

    // R10: pass bits move only on an armed START
    p_ok_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_test && start_evt) |=> $stable(ok_q));
endmodule

// File: rtl/lumo_i2c_target.sv
module lumo_i2c_target import lumo_pkg::*; #(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter int         NUM_CTL  = 5,
    parameter int         NUM_OK   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    output logic                 sda_o,
    input  logic [NUM_OK-1:0]    test_ok_i,
    output logic [NUM_CTL*8-1:0] ctl_o,
    output logic [3:0]           mode_o,
    output logic [3:0]           boost_o,
    output logic [3:0]           thresh_o,
    output logic                 self_test_o
);
    localparam logic [3:0] BITS = 4'd8;

    lumo_st_t   st, nxt;
    logic       scl_s, sda_s, scl_q, sda_q;
    logic       scl_rise, scl_fall, start_evt, stop_evt;
    logic [3:0] cnt;
    logic [7:0] shreg, ptr, txsh, rd_data;
    logic       rw_q, mack_q, wr_en;
    logic       byte_done, addr_hit, in_ack;

    lumo_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
    );

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    assign byte_done = (cnt == BITS);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign in_ack    = (st == S_ADDR_ACK) || (st == S_PTR_ACK) ||
                       (st == S_DATA_ACK) || (st == S_TX_ACK);

    always_comb begin
        nxt = st;
        if (stop_evt) begin
            nxt = S_IDLE;
        end else if (start_evt) begin
            nxt = S_ADDR;
        end else if (scl_fall) begin
            unique case (st)
                S_ADDR:     if (byte_done) nxt = addr_hit ? S_ADDR_ACK : S_IDLE;
                S_ADDR_ACK: nxt = rw_q ? S_TX : S_PTR;
                S_PTR:      if (byte_done) nxt = S_PTR_ACK;
                S_PTR_ACK:  nxt = S_DATA;
                S_DATA:     if (byte_done) nxt = S_DATA_ACK;
                S_DATA_ACK: nxt = S_DATA;
                S_TX:       if (byte_done) nxt = S_TX_ACK;
                S_TX_ACK:   nxt = mack_q ? S_TX : S_IDLE;
                default:    nxt = st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            cnt    <= '0;
            shreg  <= '0;
            ptr    <= '0;
            txsh   <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
            if (start_evt || stop_evt) begin
                cnt <= '0;
            end else if (scl_rise) begin
                if (cnt != 4'hF) cnt <= cnt + 4'd1;
                shreg <= {shreg[6:0], sda_s};
                if (st == S_TX_ACK) mack_q <= ~sda_s;
            end else if (scl_fall) begin
                if (in_ack) cnt <= '0;
                if (st == S_ADDR && byte_done) rw_q <= shreg[0];
                if (st == S_PTR && byte_done)  ptr  <= shreg;
                if ((st == S_ADDR_ACK && rw_q) || (st == S_TX_ACK && mack_q))
                    txsh <= rd_data;
                else if (st == S_TX && !byte_done)
                    txsh <= {txsh[6:0], 1'b0};
            end
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        sda_o  = 1'b1;
        unique case (st)
            S_ADDR_ACK, S_PTR_ACK, S_DATA_ACK: begin
                sda_oe = 1'b1;
                sda_o  = 1'b0;
            end
            S_TX: begin
                sda_oe = 1'b1;
                sda_o  = txsh[7];
            end
            default: ;
        endcase
        wr_en = (st == S_DATA) && scl_fall && byte_done;
    end

    lumo_regs #(.NUM_CTL(NUM_CTL), .NUM_OK(NUM_OK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
        .wr_data(shreg), .rd_addr(ptr), .rd_data(rd_data),
        .start_evt(start_evt), .test_ok_i(test_ok_i), .ctl_o(ctl_o),
        .mode_o(mode_o), .boost_o(boost_o), .thresh_o(thresh_o),
        .self_test_o(self_test_o)
    );

    // R11: STOP always returns to idle
    p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (st == S_IDLE));

    // R11: any START opens a new address phase
    p_start_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (st == S_ADDR));

    // R4: a foreign address drops back to idle
    p_miss_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADDR && scl_fall && byte_done && !addr_hit) |=> (st == S_IDLE));

    // R1: the acknowledge slot lasts until the bus clock falls
    p_ack_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADDR_ACK && !scl_fall && !start_evt && !stop_evt) |=> (st == S_ADDR_ACK));
endmodule

// File: tb/lumo_i2c_target_test.sv
`timescale 1ns/1ps
module lumo_i2c_target_test;
    localparam time Q = 40ns;
    localparam logic [7:0] WADDR = 8'h98;
    localparam logic [7:0] RADDR = 8'h99;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_bus;
    logic        sda_oe, sda_o, self_test_o;
    logic [4:0]  test_ok = 5'b0;
    logic [39:0] ctl_o;
    logic [3:0]  mode_o, boost_o, thresh_o;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = (sda_oe ? sda_o : 1'b1) & m_sda;

    lumo_i2c_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .sda_o(sda_o), .test_ok_i(test_ok),
        .ctl_o(ctl_o), .mode_o(mode_o), .boost_o(boost_o),
        .thresh_o(thresh_o), .self_test_o(self_test_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_tx(input logic b, output logic seen);
        #Q m_sda = b;
        #Q scl = 1'b1;
        #Q seen = sda_bus;
        #Q scl = 1'b0;
    endtask

    task automatic bus_start;
        #Q m_sda = 1'b1;
        #Q scl = 1'b1;
        #Q m_sda = 1'b0;
        #Q scl = 1'b0;
    endtask

    task automatic bus_stop;
        #Q m_sda = 1'b0;
        #Q scl = 1'b1;
        #Q m_sda = 1'b1;
        #Q;
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_tx(b[i], s);
        bit_tx(1'b1, s);
        ack = ~s;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_tx(1'b1, s);
            b[i] = s;
        end
        bit_tx(~give_ack, s);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        logic k0, k1, k2;
        bus_start;
        put_byte(WADDR, k0);
        put_byte(a, k1);
        put_byte(d, k2);
        bus_stop;
        chk({tag, " write acks"}, {k0, k1, k2}, 3'b111);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        logic k0, k1, k2;
        bus_start;
        put_byte(WADDR, k0);
        put_byte(a, k1);
        bus_start;
        put_byte(RADDR, k2);
        get_byte(1'b0, d);
        bus_stop;
        chk("R1 read acks", {k0, k1, k2}, 3'b111);
    endtask

    task automatic t_reset_values;
        logic [7:0] d;
        chk("R5 ctl reset", ctl_o, 40'h0);
        chk("R5 mode reset", mode_o, 4'h4);
        chk("R5 boost reset", boost_o, 4'h7);
        chk("R5 thresh reset", thresh_o, 4'h3);
        chk("R5 test bit reset", self_test_o, 1'b0);
        chk("R11 idle no drive", sda_oe, 1'b0);
        rd(8'h0B, d); chk("R5 R6 read 0x0B", d, 8'h04);
        rd(8'h0D, d); chk("R5 R7 read 0x0D", d, 8'h07);
        rd(8'h2B, d); chk("R5 R7 read 0x2B", d, 8'h03);
        rd(8'h0C, d); chk("R5 R9 read 0x0C", d, 8'h00);
    endtask

    task automatic t_write_read;
        logic [7:0] d;
        wr(8'h00, 8'hA5, "R2");
        wr(8'h04, 8'h3C, "R2");
        wr(8'h02, 8'hFF, "R2");
        chk("R2 ctl bytes", ctl_o, 40'h3C_00_FF_00_A5);
        wr(8'h02, 8'h00, "R2");
        chk("R2 all bits cleared", ctl_o, 40'h3C_00_00_00_A5);
        rd(8'h00, d); chk("R3 read 0x00", d, 8'hA5);
        rd(8'h04, d); chk("R3 read 0x04", d, 8'h3C);
    endtask

    task automatic t_burst_read;
        logic [7:0] d0, d1;
        logic k0, k1, k2;
        wr(8'h01, 8'h5A, "R2");
        bus_start;
        put_byte(WADDR, k0);
        put_byte(8'h01, k1);
        bus_start;
        put_byte(RADDR, k2);
        get_byte(1'b1, d0);
        get_byte(1'b0, d1);
        #Q;
        chk("R3 released after NACK", sda_oe, 1'b0);
        bus_stop;
        chk("R3 first byte", d0, 8'h5A);
        chk("R3 repeat after ACK", d1, 8'h5A);
    endtask

    task automatic t_foreign_addr;
        logic k0, k1, k2;
        bus_start;
        put_byte(8'h9A, k0);
        put_byte(8'h00, k1);
        put_byte(8'h77, k2);
        bus_stop;
        chk("R4 NACK and silent", {k0, k1, k2}, 3'b000);
        chk("R4 no register change", ctl_o, 40'h3C_00_00_5A_A5);
    endtask

    task automatic t_fields;
        logic [7:0] d;
        wr(8'h0B, 8'hF9, "R6");
        chk("R6 mode nibble", mode_o, 4'h9);
        rd(8'h0B, d); chk("R6 upper bits zero", d, 8'h09);
        wr(8'h0D, 8'hA2, "R7");
        wr(8'h2B, 8'h5E, "R7");
        chk("R7 boost code", boost_o, 4'h2);
        chk("R7 threshold code", thresh_o, 4'hE);
        rd(8'h2B, d); chk("R7 read 0x2B", d, 8'h0E);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        wr(8'h20, 8'h55, "R8");
        rd(8'h20, d); chk("R8 unmapped reads zero", d, 8'h00);
        rd(8'h05, d); chk("R8 past ctl range zero", d, 8'h00);
        chk("R8 ctl untouched", ctl_o, 40'h3C_00_00_5A_A5);
        chk("R8 codes untouched", {mode_o, boost_o, thresh_o}, 12'h92E);
    endtask

    task automatic t_selftest;
        logic [7:0] d;
        test_ok = 5'b10110;
        wr(8'h0C, 8'h01, "R9");
        chk("R9 request raised", self_test_o, 1'b1);
        rd(8'h0C, d);
        chk("R10 result on next START", d, 8'h2C);
        chk("R10 request cleared", self_test_o, 1'b0);
        test_ok = 5'b01001;
        wr(8'h0C, 8'h3E, "R10");
        rd(8'h0C, d);
        chk("R10 pass bits not writable", d, 8'h2C);
        wr(8'h0C, 8'h01, "R9");
        rd(8'h0C, d);
        chk("R10 second capture", d, 8'h12);
    endtask

    task automatic t_midreset;
        #Q rst_n = 1'b0;
        #Q;
        chk("R5 ctl after reset", ctl_o, 40'h0);
        chk("R5 codes after reset", {mode_o, boost_o, thresh_o}, 12'h473);
        rst_n = 1'b1;
        #Q;
    endtask

    initial begin
        #21;
        t_reset_values_pre: begin
            chk("R5 held in reset", {mode_o, boost_o, thresh_o}, 12'h473);
        end
        #20 rst_n = 1'b1;
        #Q;
        t_reset_values;
        t_write_read;
        t_burst_read;
        t_foreign_addr;
        t_fields;
        t_unmapped;
        t_selftest;
        t_midreset;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800us;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule